// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block decides, one converter sample at a time, whether the sample goes into a local FIFO. Software selects an operating mode by writing a 4-bit code. While a go mode is active the sequencer stores a configurable number of samples before the start trigger, waits for that trigger, and then stores samples until a stop trigger arrives. After the stop trigger it stores a configurable number of further samples. In single-shot operation it then holds in a finished state. In re-arm operation it waits for the FIFO to drain and then begins a new pre-trigger fill.

Samples are paced by a sample tick taken from a 4-bit clock-select code. The code picks the always-on system clock, no clock, the rising or falling edge of one of six clock-bus lines, or the rising edge of an interrupt line. At power-on the converter is not initialized. The first write of any other mode raises an initialization request, and nothing is captured until the converter answers that it is done. One 8-bit read value packs the current status code above the current mode code.

Top module: `capture_sequencer`

## Requirements
- R1: After reset, modeStatus reads 0x84 (status 8 = uninitialized, mode 4 = uninitialized), initReq is low and fifoWr is low.
- R2: A write updates the mode field (bits [3:0]) only when modeWrData[3:0] is one of 0 reset, 1 paused, 2 single-shot go, 3 re-arm go or 4 uninitialized. Other codes leave the mode unchanged. Bits [7:4] of a write are ignored, because the status field (bits [7:4]) is read-only.
- R3: Writing a mode other than 4 while the converter is uninitialized raises initReq and shows status 9 from the next cycle. No FIFO write happens until initDone is seen. initReq then drops on the next cycle. Writing mode 4 at any time returns status to 8 and requires a fresh initialization.
- R4: When mode 0 is written, the status reads 0 (stopped) on the next cycle. The counters and the sequencer return to idle, and no FIFO write occurs.
- R5: On entering a go mode (2 or 3), the block stores preCount samples with status 1 and then shows status 2 (waiting for start). When preCount is 0 it goes directly to status 2 without storing anything.
- R6: A start trigger is acted on only in status 2. It moves the block to status 3, where every sample tick produces one fifoWr pulse. A start trigger during the pre-trigger fill is ignored.
- R7: A stop trigger is acted on only in status 3. It moves the block to status 4, and exactly postCount further samples are stored. A stop trigger in any other status is ignored.
- R8: In mode 2, after the post-stop fill, the status is 7 (done) and no samples are stored until the mode is rewritten.
- R9: In mode 3, after the post-stop fill, the status is 5 while fifoEmpty is low. On the first cycle with fifoEmpty high the block starts a new pre-trigger fill (status 1).
- R10: In mode 1 (paused), fifoWr stays low, triggers are ignored, and the status and counter hold their values. Writing a go mode resumes the sequence from the same point.
- R11: The sample tick follows clkSel: 0 means every cycle, 1 and 9 mean never, 2–7 mean the rising edge of clkBus line 2–7, 8 means the rising edge of irqIn, and 0xA–0xF mean the falling edge of clkBus line 2–7. Each edge is detected against the value the line had at the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Register write strobe |
| modeWrData | input | 8 | Register write data; only bits [3:0] are used |
| modeStatus | output | 8 | {status[3:0], mode[3:0]} |
| initReq | output | 1 | Converter initialization request |
| initDone | input | 1 | Converter reports initialization complete |
| clkSel | input | 4 | Sample tick source select |
| clkBus | input | 8 | Clock-bus lines (2–7 selectable) |
| irqIn | input | 1 | Interrupt line usable as a tick source |
| startTrig | input | 1 | Start trigger strobe |
| stopTrig | input | 1 | Stop trigger strobe |
| preCount | input | CW | Samples stored before the start trigger |
| postCount | input | CW | Samples stored after the stop trigger |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoWr | output | 1 | Store the current sample into the FIFO |

## Verification
The hardest state to reach is a pause in the middle of sampling with a stop trigger held high. It takes an initialization handshake, a finished pre-trigger fill and an accepted start trigger first. The bench reaches it by stepping through that whole chain in the always-tick clock mode. It then pauses, holds the stop trigger, and checks both the write count and the frozen status before resuming. The clock-select table is walked while the block sits in the sampling state, so every tick shows up directly on fifoWr. The re-arm drain is tested by holding fifoEmpty low for several cycles after the post-stop fill.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'h0,
    ST_PRE    = 4'h1,
    ST_WAIT   = 4'h2,
    ST_SAMPLE = 4'h3,
    ST_POST   = 4'h4,
    ST_REARM  = 4'h5,
    ST_DONE   = 4'h7
  } seqState_t;

  localparam logic [3:0] MODE_RESET  = 4'h0;
  localparam logic [3:0] MODE_PAUSE  = 4'h1;
  localparam logic [3:0] MODE_SINGLE = 4'h2;
  localparam logic [3:0] MODE_REARM  = 4'h3;
  localparam logic [3:0] MODE_UNINIT = 4'h4;

  localparam logic [3:0] STAT_UNINIT = 4'h8;
  localparam logic [3:0] STAT_INIT   = 4'h9;

  typedef struct packed {
    logic wrEn;
    logic cntClr;
    logic selPost;
  } dpCtrl_t;

endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctl,
  input  logic [3:0]    clkSel,
  input  logic [7:0]    clkBus,
  input  logic          irqIn,
  input  logic [CW-1:0] preCount,
  input  logic [CW-1:0] postCount,
  output logic          lastHit,
  output logic          preZero,
  output logic          postZero,
  output logic          tick,
  output logic          fifoWr
);
  localparam int LINES = 8;

  logic [LINES-1:0] busPrev;
  logic             irqPrev;
  logic [LINES-1:0] busRise, busFall;
  logic [CW-1:0]    cnt, target;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busPrev <= '0;
      irqPrev <= 1'b0;
    end else begin
      busPrev <= clkBus;
      irqPrev <= irqIn;
    end
  end

  assign busRise = clkBus & ~busPrev;
  assign busFall = ~clkBus & busPrev;

  always_comb begin
    case (clkSel)
      4'h0:    tick = 1'b1;
      4'h1:    tick = 1'b0;
      4'h8:    tick = irqIn & ~irqPrev;
      4'h9:    tick = 1'b0;
      default: tick = clkSel[3] ? busFall[clkSel[2:0]] : busRise[clkSel[2:0]];
    endcase
  end

  assign fifoWr = ctl.wrEn & tick;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) cnt <= '0;
    else if (fifoWr)         cnt <= cnt + CW'(1);
  end

  assign target   = ctl.selPost ? postCount : preCount;
  assign lastHit  = (cnt == target - CW'(1));
  assign preZero  = (preCount == '0);
  assign postZero = (postCount == '0);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [7:0] modeWrData,
  input  logic       initDone,
  input  logic       startTrig,
  input  logic       stopTrig,
  input  logic       fifoEmpty,
  input  logic       tick,
  input  logic       lastHit,
  input  logic       preZero,
  input  logic       postZero,
  output dpCtrl_t    ctl,
  output logic [7:0] modeStatus,
  output logic       initReq
);
  logic [3:0] modeQ;
  logic       convReady, initBusy;
  seqState_t  state, stateNext, finishState, armState;
  logic       wrValid, fillDone;
  logic [3:0] statusV;
  logic [3:0] unusedHi;

  assign unusedHi = modeWrData[7:4];
  assign wrValid  = modeWrEn && (modeWrData[3:0] <= MODE_UNINIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_UNINIT;
      convReady <= 1'b0;
      initBusy  <= 1'b0;
      state     <= ST_IDLE;
    end else begin
      if (wrValid) modeQ <= modeWrData[3:0];
      if (wrValid && modeWrData[3:0] == MODE_UNINIT) begin
        convReady <= 1'b0;
        initBusy  <= 1'b0;
      end else if (!convReady) begin
        if (initBusy && initDone) begin
          initBusy  <= 1'b0;
          convReady <= 1'b1;
        end else if (wrValid) begin
          initBusy <= 1'b1;
        end
      end
      state <= stateNext;
    end
  end

  always_comb begin
    ctl         = '{wrEn: 1'b0, cntClr: 1'b1, selPost: 1'b0};
    stateNext   = state;
    fillDone    = tick & lastHit;
    finishState = (modeQ == MODE_REARM) ? ST_REARM : ST_DONE;
    armState    = preZero ? ST_WAIT : ST_PRE;
    if (!convReady || modeQ == MODE_UNINIT || modeQ == MODE_RESET) begin
      stateNext = ST_IDLE;
    end else if (modeQ == MODE_PAUSE) begin
      ctl.cntClr = 1'b0;
    end else begin
      case (state)
        ST_IDLE: stateNext = armState;
        ST_PRE: begin
          ctl.wrEn   = 1'b1;
          ctl.cntClr = 1'b0;
          if (fillDone) stateNext = ST_WAIT;
        end
        ST_WAIT: if (startTrig) stateNext = ST_SAMPLE;
        ST_SAMPLE: begin
          ctl.wrEn = 1'b1;
          if (stopTrig) stateNext = postZero ? finishState : ST_POST;
        end
        ST_POST: begin
          ctl.wrEn    = 1'b1;
          ctl.cntClr  = 1'b0;
          ctl.selPost = 1'b1;
          if (fillDone) stateNext = finishState;
        end
        ST_REARM: if (fifoEmpty) stateNext = armState;
        ST_DONE:  stateNext = ST_DONE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!convReady)               statusV = initBusy ? STAT_INIT : STAT_UNINIT;
    else if (modeQ == MODE_RESET) statusV = ST_IDLE;
    else                          statusV = state;
  end

  assign modeStatus = {statusV, modeQ};
  assign initReq    = initBusy;

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modeWrEn,
  input  logic [7:0]    modeWrData,
  output logic [7:0]    modeStatus,
  output logic          initReq,
  input  logic          initDone,
  input  logic [3:0]    clkSel,
  input  logic [7:0]    clkBus,
  input  logic          irqIn,
  input  logic          startTrig,
  input  logic          stopTrig,
  input  logic [CW-1:0] preCount,
  input  logic [CW-1:0] postCount,
  input  logic          fifoEmpty,
  output logic          fifoWr
);
  dpCtrl_t ctl;
  logic    tick, lastHit, preZero, postZero;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .initDone(initDone), .startTrig(startTrig), .stopTrig(stopTrig),
    .fifoEmpty(fifoEmpty), .tick(tick), .lastHit(lastHit),
    .preZero(preZero), .postZero(postZero), .ctl(ctl),
    .modeStatus(modeStatus), .initReq(initReq)
  );

  seq_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkSel(clkSel), .clkBus(clkBus),
    .irqIn(irqIn), .preCount(preCount), .postCount(postCount),
    .lastHit(lastHit), .preZero(preZero), .postZero(postZero),
    .tick(tick), .fifoWr(fifoWr)
  );

endmodule

// File: rtl/capture_sequencer_chk.sv
module capture_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeWrEn,
  input logic [7:0] modeStatus,
  input logic       initReq,
  input logic       fifoEmpty,
  input logic       fifoWr
);
  logic [3:0] statusF, modeF;
  assign statusF = modeStatus[7:4];
  assign modeF   = modeStatus[3:0];

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeF <= 4'h4);

  assert_init_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    initReq |-> (statusF == 4'h9 && !fifoWr));

  assert_reset_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == 4'h0) |-> (statusF == 4'h0 || statusF == 4'h8 || statusF == 4'h9));

  assert_wr_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> (statusF == 4'h1 || statusF == 4'h3 || statusF == 4'h4));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusF == 4'h7 && !modeWrEn) |=> (statusF == 4'h7));

  assert_rearm_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusF == 4'h5 && modeF == 4'h3 && !fifoEmpty && !modeWrEn) |=> (statusF == 4'h5));

  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeF == 4'h1 && statusF != 4'h8 && statusF != 4'h9 && !modeWrEn) |=> $stable(modeStatus));

endmodule

bind capture_sequencer capture_sequencer_chk u_chk (.*);

// File: tb/capture_sequencer_bench.sv
module capture_sequencer_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeWrEn = 1'b0;
  logic [7:0]    modeWrData = '0;
  logic [7:0]    modeStatus;
  logic          initReq;
  logic          initDone = 1'b0;
  logic [3:0]    clkSel = 4'h0;
  logic [7:0]    clkBus = '0;
  logic          irqIn = 1'b0;
  logic          startTrig = 1'b0;
  logic          stopTrig = 1'b0;
  logic [CW-1:0] preCount = '0;
  logic [CW-1:0] postCount = '0;
  logic          fifoEmpty = 1'b0;
  logic          fifoWr;

  int checks = 0;
  int errors = 0;
  int wrCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  capture_sequencer #(.CW(CW)) u_capture_sequencer (.*);

  // {clkSel, line value at previous clock, line value now, expected tick}
  localparam logic [6:0] SEL_VEC [12] = '{
    {4'h0, 1'b0, 1'b0, 1'b1}, {4'h1, 1'b1, 1'b1, 1'b0},
    {4'h2, 1'b0, 1'b1, 1'b1}, {4'h2, 1'b1, 1'b0, 1'b0},
    {4'h2, 1'b1, 1'b1, 1'b0}, {4'h7, 1'b0, 1'b1, 1'b1},
    {4'h8, 1'b0, 1'b1, 1'b1}, {4'h8, 1'b1, 1'b0, 1'b0},
    {4'h9, 1'b0, 1'b1, 1'b0}, {4'hA, 1'b1, 1'b0, 1'b1},
    {4'hA, 1'b0, 1'b1, 1'b0}, {4'hF, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expStat(input string req, input logic [7:0] exp);
    check(modeStatus == exp, req, modeStatus, exp);
  endtask

  // Inputs change at posedge+1; fifoWr is counted just after the negedge.
  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (fifoWr) wrCnt++;
      @(posedge clk); #1;
    end
  endtask

  task automatic writeMode(input logic [7:0] v);
    modeWrEn = 1'b1;
    modeWrData = v;
    adv(1);
    modeWrEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: power-on state
    expStat("R1", 8'h84);
    check(!initReq, "R1 initReq", initReq, 0);
    #4 check(!fifoWr, "R1 fifoWr", fifoWr, 0);
    @(posedge clk); #1;

    // R3: leaving uninitialized requests initialization
    writeMode(8'h00);
    expStat("R3", 8'h90);
    check(initReq, "R3 initReq", initReq, 1);
    preCount = 3; postCount = 2;
    writeMode(8'h02);
    wrCnt = 0;
    adv(4);
    expStat("R3 waiting", 8'h92);
    check(wrCnt == 0, "R3 no writes", wrCnt, 0);
    initDone = 1'b1; adv(1); initDone = 1'b0;
    expStat("R3 done", 8'h02);
    check(!initReq, "R3 initReq drop", initReq, 0);

    // R5: pre-trigger fill
    adv(1);
    expStat("R5 prefill", 8'h12);
    wrCnt = 0;
    adv(3);
    expStat("R5 waiting", 8'h22);
    check(wrCnt == 3, "R5 pre count", wrCnt, 3);
    adv(5);
    check(wrCnt == 3, "R5 no writes while waiting", wrCnt, 3);

    // R6: start trigger
    startTrig = 1'b1; adv(1); startTrig = 1'b0;
    expStat("R6 sampling", 8'h32);
    adv(4);
    check(wrCnt == 7, "R6 sample writes", wrCnt, 7);

    // R10: pause with a stop trigger held
    writeMode(8'h01);
    expStat("R10 paused", 8'h31);
    stopTrig = 1'b1; adv(5); stopTrig = 1'b0;
    expStat("R10 held", 8'h31);
    check(wrCnt == 8, "R10 no writes", wrCnt, 8);
    writeMode(8'h02);
    expStat("R10 resumed", 8'h32);

    // R7 / R8: post-stop fill, single-shot done
    stopTrig = 1'b1; adv(1); stopTrig = 1'b0;
    expStat("R7 postfill", 8'h42);
    adv(2);
    expStat("R8 done", 8'h72);
    check(wrCnt == 11, "R7 post count", wrCnt, 11);
    startTrig = 1'b1; adv(3); startTrig = 1'b0;
    expStat("R8 hold", 8'h72);
    check(wrCnt == 11, "R8 no writes", wrCnt, 11);

    // R4: reset mode
    writeMode(8'h00);
    expStat("R4 stopped", 8'h00);
    adv(2);
    expStat("R4 idle", 8'h00);

    // R5: zero pre-count goes straight to waiting
    preCount = 0;
    writeMode(8'h02);
    wrCnt = 0;
    adv(1);
    expStat("R5 zero pre", 8'h22);
    check(wrCnt == 0, "R5 zero pre writes", wrCnt, 0);

    // R11: clock select table walked in the sampling state
    startTrig = 1'b1; adv(1); startTrig = 1'b0;
    expStat("R11 setup", 8'h32);
    for (int k = 0; k < 12; k++) begin
      clkSel = SEL_VEC[k][6:3];
      clkBus = {8{SEL_VEC[k][2]}};
      irqIn  = SEL_VEC[k][2];
      adv(1);
      clkBus = {8{SEL_VEC[k][1]}};
      irqIn  = SEL_VEC[k][1];
      #1 check(fifoWr == SEL_VEC[k][0], "R11 clkSel", fifoWr, SEL_VEC[k][0]);
      adv(1);
    end
    clkSel = 4'h0; clkBus = '0; irqIn = 1'b0;

    // R9: re-arm
    writeMode(8'h00);
    preCount = 2; postCount = 1; fifoEmpty = 1'b0;
    writeMode(8'h03);
    expStat("R9 armed", 8'h03);
    adv(1);
    expStat("R9 prefill", 8'h13);
    startTrig = 1'b1; adv(2); startTrig = 1'b0;
    expStat("R6 start ignored in prefill", 8'h23);
    stopTrig = 1'b1; adv(1); stopTrig = 1'b0;
    expStat("R7 stop ignored while waiting", 8'h23);
    startTrig = 1'b1; adv(1); startTrig = 1'b0;
    stopTrig = 1'b1; adv(1); stopTrig = 1'b0;
    expStat("R9 post", 8'h43);
    wrCnt = 0;
    adv(1);
    expStat("R9 wait drain", 8'h53);
    adv(3);
    expStat("R9 still draining", 8'h53);
    check(wrCnt == 1, "R9 post count", wrCnt, 1);
    fifoEmpty = 1'b1; adv(1);
    expStat("R9 refill", 8'h13);

    // R3: writing uninitialized again
    writeMode(8'h04);
    expStat("R3 uninit", 8'h84);
    check(!initReq, "R3 uninit initReq", initReq, 0);
    writeMode(8'h00);
    expStat("R3 reinit", 8'h90);
    initDone = 1'b1; adv(1); initDone = 1'b0;
    expStat("R3 ready", 8'h00);

    // R2: undefined codes and status bits ignored
    writeMode(8'h02);
    writeMode(8'h07);
    check(modeStatus[3:0] == 4'h2, "R2 invalid code", modeStatus[3:0], 2);
    writeMode(8'h50);
    expStat("R2 status bits ignored", 8'h00);

    finish();
  end
endmodule